// File: doc/BRIEF.md
# Pulse-Length Coded Field Command Encoder

This block turns a short command into the on/off carrier-enable waveform that a low-frequency reader uses to talk to a tag. Modulation is full on/off keying: a low on the enable output switches the field off, and a high switches it on. Time is counted in field units. A configurable divider makes one unit out of a fixed number of system clock cycles.

A host presents up to 32 command bits and a bit count, then pulses start. The block holds the field on for a long lead-in. Each bit is then sent as a short field-off gap followed by a field-on stretch, and the length of that stretch tells whether the bit is a zero or a one. After the last bit comes an end-of-frame marker, which is the same gap followed by an even longer field-on stretch. When the frame is finished, the field is left on so the tag keeps power while it answers.

Top module: `plc_ask_encoder`

## Requirements
- R1: After reset, field_on_o, busy_o and done_o are all low.
- R2: When start_i is high at a clock edge while busy_o is low and bit_cnt_i is nonzero, busy_o and field_on_o are both high from the next cycle. The field then stays on for a 170-unit lead-in. One unit is exactly UNIT_DIV clock cycles, and every segment lasts its unit count times UNIT_DIV cycles.
- R3: Every command bit is an 8-unit field-off gap followed by field on. The on stretch is 18 units for a zero bit and 28 units for a one bit.
- R4: Bits go out starting with cmd_bits_i[0] and then in ascending index order. cmd_bits_i and bit_cnt_i are captured at the accepting edge.
- R5: After the last bit, the frame ends with an 8-unit field-off gap followed by 38 units of field on.
- R6: busy_o stays high up to and including the last cycle of the end marker. In the next cycle busy_o is low and done_o is high, and done_o lasts exactly that one cycle.
- R7: After a frame, field_on_o stays high until the next accepted start.
- R8: A start_i pulse while busy_o is high has no effect. The waveform in progress continues unchanged, and the new cmd_bits_i and bit_cnt_i values are not captured.
- R9: A start_i pulse with bit_cnt_i equal to 0 produces no waveform. busy_o and done_o stay low and field_on_o keeps its level.
- R10: A bit_cnt_i value above 32 is treated as 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send a frame |
| cmd_bits_i | input | 32 | Command bits; index 0 is sent first |
| bit_cnt_i | input | 6 | Number of bits to send (0 means no frame, values above 32 are treated as 32) |
| field_on_o | output | 1 | Carrier enable: 1 means field on, 0 means field off |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse after the end marker |

## Verification
Every output is a register, so the reaction to an accepted start shows up exactly one cycle after the accepting edge. From there, each segment of a frame lasts its unit count times UNIT_DIV cycles, and the end marker is followed by done_o in the very next cycle. The bench drives inputs and samples outputs on falling edges. It walks a computed list of segments cycle by cycle and requires the expected field level, with busy_o high and done_o low, on every cycle of each segment. After the last segment it checks done_o and busy_o in the first cycle and again in the second. Starts issued while busy, and starts with a zero count, are checked by watching the same outputs on each cycle that follows.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_GAP,
    PH_MARK,
    PH_EOF
  } phase_e;
endpackage

// File: rtl/plc_unit_tick.sv
module plc_unit_tick #(
  parameter int unsigned DIV = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap   = (pre_q == PW'(DIV - 1));
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pre_q <= '0;
    else if (!run_i)      pre_q <= '0;
    else if (wrap)        pre_q <= '0;
    else                  pre_q <= pre_q + 1'b1;
  end

  // R2: prescaler never leaves its range, so a unit is exactly DIV cycles
  a_r2_pre_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PW'(DIV - 1));
  // R2: prescaler restarts from zero whenever the frame is idle
  a_r2_pre_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> pre_q == '0);
endmodule

// File: rtl/plc_bit_queue.sv
module plc_bit_queue #(
  parameter int unsigned MAX_BITS = 32,
  localparam int unsigned CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [MAX_BITS-1:0] bits_i,
  input  logic [CW-1:0]       cnt_i,
  input  logic                shift_i,
  output logic                cur_bit_o,
  output logic                empty_o
);
  logic [MAX_BITS-1:0] sh_q;
  logic [CW-1:0]       rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      sh_q  <= bits_i;
      rem_q <= (cnt_i > CW'(MAX_BITS)) ? CW'(MAX_BITS) : cnt_i;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      rem_q <= rem_q - 1'b1;
    end
  end

  assign cur_bit_o = sh_q[0];
  assign empty_o   = (rem_q == '0);

  // R10: remaining count is clamped to the buffer size
  a_r10_rem_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CW'(MAX_BITS));
  // R4: the sequencer never consumes a bit that is not there
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !empty_o);
endmodule

// File: rtl/plc_frame_seq.sv
module plc_frame_seq
  import plc_pkg::*;
#(
  parameter int unsigned LEAD_UNITS = 170,
  parameter int unsigned GAP_UNITS  = 8,
  parameter int unsigned ZERO_UNITS = 18,
  parameter int unsigned ONE_UNITS  = 28,
  parameter int unsigned EOF_UNITS  = 38
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cnt_nz_i,
  input  logic tick_i,
  input  logic cur_bit_i,
  input  logic empty_i,
  output logic load_o,
  output logic shift_o,
  output logic field_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned SW =
    $clog2(LEAD_UNITS + GAP_UNITS + ZERO_UNITS + ONE_UNITS + EOF_UNITS + 1);

  phase_e        phase_q;
  logic [SW-1:0] seg_q;
  logic          field_q;
  logic          done_q;
  logic          accept;
  logic          seg_end;

  assign busy_o  = (phase_q != PH_IDLE);
  assign accept  = start_i && !busy_o && cnt_nz_i;
  assign seg_end = tick_i && (seg_q == SW'(1));
  assign load_o  = accept;
  assign shift_o = (phase_q == PH_MARK) && seg_end;
  assign field_o = field_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      seg_q   <= '0;
      field_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE) begin
        if (accept) begin
          phase_q <= PH_LEAD;
          seg_q   <= SW'(LEAD_UNITS);
          field_q <= 1'b1;
        end
      end else if (tick_i) begin
        if (!seg_end) begin
          seg_q <= seg_q - 1'b1;
        end else begin
          unique case (phase_q)
            PH_LEAD, PH_MARK: begin
              phase_q <= PH_GAP;
              seg_q   <= SW'(GAP_UNITS);
              field_q <= 1'b0;
            end
            PH_GAP: begin
              field_q <= 1'b1;
              if (empty_i) begin
                phase_q <= PH_EOF;
                seg_q   <= SW'(EOF_UNITS);
              end else begin
                phase_q <= PH_MARK;
                seg_q   <= cur_bit_i ? SW'(ONE_UNITS) : SW'(ZERO_UNITS);
              end
            end
            PH_EOF: begin
              phase_q <= PH_IDLE;
              seg_q   <= '0;
              done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R2: accepted start opens the lead-in with the field on
  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && field_o && phase_q == PH_LEAD);
  // R3: the field is off during every gap
  a_r3_gap_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_GAP) |-> !field_q);
  // R6: done never overlaps busy
  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6, R7: frame ends with done and the field left on
  a_r7_field_after: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o && field_o);
  // R8: nothing moves between unit ticks, start while busy included
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(seg_q) && $stable(phase_q) && $stable(field_q));
  // R9: zero-length request starts nothing
  a_r9_zero_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !cnt_nz_i |=> !busy_o && !done_o && $stable(field_o));
endmodule

// File: rtl/plc_ask_encoder.sv
module plc_ask_encoder #(
  parameter int unsigned MAX_BITS   = 32,
  parameter int unsigned UNIT_DIV   = 2000,
  parameter int unsigned LEAD_UNITS = 170,
  parameter int unsigned GAP_UNITS  = 8,
  parameter int unsigned ZERO_UNITS = 18,
  parameter int unsigned ONE_UNITS  = 28,
  parameter int unsigned EOF_UNITS  = 38,
  localparam int unsigned CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MAX_BITS-1:0] cmd_bits_i,
  input  logic [CW-1:0]       bit_cnt_i,
  output logic                field_on_o,
  output logic                busy_o,
  output logic                done_o
);
  logic tick;
  logic load;
  logic shift;
  logic cur_bit;
  logic empty;

  plc_unit_tick #(.DIV(UNIT_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .tick_o (tick)
  );

  plc_bit_queue #(.MAX_BITS(MAX_BITS)) u_queue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .bits_i    (cmd_bits_i),
    .cnt_i     (bit_cnt_i),
    .shift_i   (shift),
    .cur_bit_o (cur_bit),
    .empty_o   (empty)
  );

  plc_frame_seq #(
    .LEAD_UNITS (LEAD_UNITS),
    .GAP_UNITS  (GAP_UNITS),
    .ZERO_UNITS (ZERO_UNITS),
    .ONE_UNITS  (ONE_UNITS),
    .EOF_UNITS  (EOF_UNITS)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cnt_nz_i  (|bit_cnt_i),
    .tick_i    (tick),
    .cur_bit_i (cur_bit),
    .empty_i   (empty),
    .load_o    (load),
    .shift_o   (shift),
    .field_o   (field_on_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  // R1: outputs quiet straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> !busy_o && !done_o && !field_on_o);
endmodule

// File: tb/plc_ask_encoder_bench.sv
`timescale 1ns/1ps
module plc_ask_encoder_bench;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cmd = '0;
  logic [5:0]  cnt = '0;
  logic        field, busy, done;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  plc_ask_encoder #(.UNIT_DIV(DIV)) u_plc_ask_encoder (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .cmd_bits_i (cmd),
    .bit_cnt_i  (cnt),
    .field_on_o (field),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int on_units(input bit b);
    return b ? 28 : 18;
  endfunction

  // walks one segment cycle by cycle; optional start pulse mid-segment (R8)
  task automatic seg(input bit lvl, input int units, input string tag, input bit poke);
    int bad = 0;
    for (int c = 0; c < units * DIV; c++) begin
      if (field !== lvl || busy !== 1'b1 || done !== 1'b0) bad++;
      if (poke && c == 5) begin start = 1'b1; cmd = ~cmd; cnt = 6'd1; end
      if (poke && c == 6) start = 1'b0;
      @(negedge clk);
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic run_frame(input logic [31:0] bits, input int n_req, input bit poke);
    int n = (n_req > 32) ? 32 : n_req;
    start = 1'b1; cmd = bits; cnt = 6'(n_req);
    @(negedge clk);
    start = 1'b0;
    seg(1'b1, 170, "R2 lead-in", poke);
    for (int i = 0; i < n; i++) begin
      seg(1'b0, 8, "R3 bit gap", 1'b0);
      seg(1'b1, on_units(bits[i]), (i == 31) ? "R10 R4 bit on" : "R4 R3 bit on", poke && i == 0);
    end
    seg(1'b0, 8, "R5 eof gap", 1'b0);
    seg(1'b1, 38, "R5 eof on", 1'b0);
    check(done === 1'b1 && busy === 1'b0, "R6 done after eof", {done, busy}, 2);
    check(field === 1'b1, "R7 field on at end", field, 1);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R6 done one cycle", {done, busy}, 0);
    check(field === 1'b1, "R7 field held", field, 1);
  endtask

  task automatic zero_req(input bit lvl);
    int bad = 0;
    start = 1'b1; cmd = 32'hFFFF_FFFF; cnt = 6'd0;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (busy !== 1'b0 || done !== 1'b0 || field !== lvl) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R9 zero count", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(field === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset", {field, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(field === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 after release", {field, busy, done}, 0);
    zero_req(1'b0);
    run_frame(32'h0000_0000, 1, 1'b0);
    run_frame(32'h0000_0001, 1, 1'b0);
    run_frame(32'h0000_0036, 6, 1'b1);
    zero_req(1'b1);
    run_frame(32'hA5C3_0F96, 40, 1'b0);
    run_frame(32'hFFFF_FFFF, 32, 1'b1);
    for (int k = 0; k < 5; k++) begin
      run_frame($urandom(), int'($urandom_range(1, 32)), k[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule